// File: doc/BRIEF.md
# Cascadable Fall-Through Dual-Clock FIFO

This block is a two-clock FIFO that presents each stored word on its data output without waiting for a read request. The write side takes a word on a rising write-clock edge when the active-low write strobe is low. The read side shows the oldest word together with an active-low "data valid" flag, and drops that word on a rising read-clock edge when the active-low read strobe is low. An active-low "space free" flag on the write side reports room for at least one more word.

Both flags are active-low and have fixed cycle latencies, so identical instances can be chained with no glue logic. The valid flag of one instance drives the write strobe of the next one, and the space flag of the next instance drives the read strobe of the one before it. The first word written into an empty chain ripples down to the last output by itself. A slot freed at the end of a full chain bubbles back up to the first input. One instance holds DEPTH words in its array plus one word in its output register, and a chain holds the sum of its instances. An active-low output enable only masks the data output. A master reset empties the storage and leaves the block in fall-through operation, which is the only mode it has.

The read side is a two-state machine. RD_EMPTY means the output register holds nothing, and the valid flag is high. RD_SHOW means a word is presented, and the valid flag is low. RD_EMPTY moves to RD_SHOW when the synchronized write pointer shows a stored word, and that word is loaded. RD_SHOW stays in RD_SHOW when no read is requested, or when a read is requested and another stored word is ready to be loaded at the same edge. RD_SHOW returns to RD_EMPTY when a read is requested and no stored word is ready.

Top module: `cff_fifo`

## Requirements
- R1: While and after master reset (mrs_n low), or_n is 1 and ir_n is 0, and all earlier contents are discarded.
- R2: A word written to an empty instance at write edge E0 is shown on q, with or_n low, after read-clock edge 3 counted from E0 when both clocks are the same clock. No read request is needed.
- R3: While or_n is low and ren_n is high, q and or_n hold their values.
- R4: A read (ren_n low while or_n low) consumes the shown word. If another stored word is already visible to the read side, it is shown after that same edge. Otherwise or_n returns high.
- R5: ir_n is high when the array holds DEPTH words, so one instance accepts DEPTH+1 words. A write attempted while ir_n is high is ignored.
- R6: A read attempted while or_n is high is ignored, and later writes are still delivered intact.
- R7: After a read from a full instance, ir_n goes low 2 write-clock edges after the read edge.
- R8: oe_n high forces q to all zeros and q_oe to 0. It does not change or_n, ir_n or the stored words.
- R9: In a two-instance chain with one shared clock, the first word reaches the last or_n 7 edges after it is written, and ir_n of the first instance falls 5 edges after one read from the full chain.
- R10: A chain of two instances accepts 2*(DEPTH+1) words.
- R11: Words leave in the order they were accepted, with none lost or duplicated, under any pattern of write and read stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mrs_n | input | 1 | Master reset, active low, asynchronous to both clocks |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write strobe, active low |
| d | input | DATA_W | Write data |
| ir_n | output | 1 | Space free, active low (write domain) |
| rclk | input | 1 | Read clock, must run continuously |
| ren_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| or_n | output | 1 | Word valid on q, active low (read domain) |
| q | output | DATA_W | Oldest word, zero while masked |
| q_oe | output | 1 | High while q is driven |

## Verification
The assertions take for granted that mrs_n is applied to both clock domains together and is released away from either clock edge. They also take for granted that wen_n, ren_n and d are steady around the rising edge of their own clock. The occupancy bounds are checked from each side through the synchronized pointers, so they rely on the reset clearing both domains at once. The bench drives every input on the falling edge and releases reset on a falling edge. It runs all clocks from one source, which makes the 3-, 5- and 7-edge latencies exact. It also gates the random writes with the sampled ir_n, so every accepted word is known to the scoreboard.

// File: rtl/cff_pkg.sv
package cff_pkg;

    // Read-side presentation state: nothing shown, or a word on q.
    typedef enum logic {
        RD_EMPTY = 1'b0,
        RD_SHOW  = 1'b1
    } rd_state_t;

    // Depth of every clock-crossing synchronizer.
    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/cff_sync.sv
module cff_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/cff_ram.sv
module cff_ram #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read: the read side loads its output register from here.
    assign rdata = mem[raddr];

endmodule

// File: rtl/cff_wr_ctrl.sv
module cff_wr_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              mrs_n,
    input  logic              wen_n,
    input  logic [ADDR_W:0]   rq2,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic              ir_n
);

    localparam int PTR_W = ADDR_W + 1;

    logic             full;
    logic [PTR_W-1:0] wbin_nx;

    // Full: gray pointers differ only in the two top bits.
    assign full    = (wgray == {~rq2[PTR_W-1:PTR_W-2], rq2[PTR_W-3:0]});
    assign we      = !wen_n && !full;
    assign wbin_nx = we ? wbin + PTR_W'(1) : wbin;

    always_ff @(posedge wclk or negedge mrs_n) begin
        if (!mrs_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign waddr = wbin[ADDR_W-1:0];
    assign ir_n  = full;

endmodule

// File: rtl/cff_rd_ctrl.sv
module cff_rd_ctrl
    import cff_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              rclk,
    input  logic              mrs_n,
    input  logic              ren_n,
    input  logic [ADDR_W:0]   wq2,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] dout,
    output logic              or_n
);

    localparam int PTR_W = ADDR_W + 1;

    rd_state_t        state, state_nx;
    logic             ram_ready;
    logic             take;
    logic             load;
    logic [PTR_W-1:0] rbin_nx;

    assign ram_ready = (rgray != wq2);
    assign take      = (state == RD_SHOW) && !ren_n;

    // Next state and load decision.
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            RD_EMPTY: begin
                if (ram_ready) begin
                    load     = 1'b1;
                    state_nx = RD_SHOW;
                end
            end
            RD_SHOW: begin
                if (take) begin
                    if (ram_ready) begin
                        load     = 1'b1;
                        state_nx = RD_SHOW;
                    end else begin
                        state_nx = RD_EMPTY;
                    end
                end
            end
            default: state_nx = RD_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge rclk or negedge mrs_n) begin
        if (!mrs_n) begin
            state <= RD_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    assign rbin_nx = load ? rbin + PTR_W'(1) : rbin;

    // Output register and read pointer.
    always_ff @(posedge rclk or negedge mrs_n) begin
        if (!mrs_n) begin
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            if (load) begin
                dout <= rdata;
            end
        end
    end

    assign raddr = rbin[ADDR_W-1:0];
    assign or_n  = (state != RD_SHOW);

endmodule

// File: rtl/cff_fifo.sv
module cff_fifo #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 16
) (
    input  logic              mrs_n,
    input  logic              wclk,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] d,
    output logic              ir_n,
    input  logic              rclk,
    input  logic              ren_n,
    input  logic              oe_n,
    output logic              or_n,
    output logic [DATA_W-1:0] q,
    output logic              q_oe
);

    // DEPTH must be a power of two, at least 4.
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] dout;
    logic [PTR_W-1:0]  wbin, wgray, rbin, rgray, wq2, rq2;

    cff_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk (wclk),
        .we   (we),
        .waddr(waddr),
        .wdata(d),
        .raddr(raddr),
        .rdata(rdata)
    );

    cff_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk (wclk),
        .mrs_n(mrs_n),
        .wen_n(wen_n),
        .rq2  (rq2),
        .we   (we),
        .waddr(waddr),
        .wbin (wbin),
        .wgray(wgray),
        .ir_n (ir_n)
    );

    cff_sync #(.W(PTR_W), .STAGES(cff_pkg::SYNC_STAGES)) u_w2r (
        .clk  (rclk),
        .rst_n(mrs_n),
        .din  (wgray),
        .dout (wq2)
    );

    cff_sync #(.W(PTR_W), .STAGES(cff_pkg::SYNC_STAGES)) u_r2w (
        .clk  (wclk),
        .rst_n(mrs_n),
        .din  (rgray),
        .dout (rq2)
    );

    cff_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rclk (rclk),
        .mrs_n(mrs_n),
        .ren_n(ren_n),
        .wq2  (wq2),
        .rdata(rdata),
        .raddr(raddr),
        .rbin (rbin),
        .rgray(rgray),
        .dout (dout),
        .or_n (or_n)
    );

    // Output enable masks data only; flags and pointers ignore it.
    assign q    = oe_n ? '0 : dout;
    assign q_oe = !oe_n;

endmodule

// File: rtl/cff_fifo_chk.sv
module cff_fifo_chk #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = 5
) (
    input logic              wclk,
    input logic              rclk,
    input logic              mrs_n,
    input logic              wen_n,
    input logic              ren_n,
    input logic              ir_n,
    input logic              or_n,
    input logic [DATA_W-1:0] dout,
    input logic [PTR_W-1:0]  wbin,
    input logic [PTR_W-1:0]  wgray,
    input logic [PTR_W-1:0]  rbin,
    input logic [PTR_W-1:0]  rgray,
    input logic [PTR_W-1:0]  wq2,
    input logic [PTR_W-1:0]  rq2
);

    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // R5: write side never counts more than DEPTH words in the array.
    assert_no_overflow_R5: assert property (@(posedge wclk) disable iff (!mrs_n)
        (wbin - g2b(rq2)) <= DEPTH_P);

    // R5: a write while ir_n is high leaves the write pointer alone.
    assert_full_ignore_R5: assert property (@(posedge wclk) disable iff (!mrs_n)
        (ir_n && !wen_n) |=> $stable(wbin));

    // R4: the read pointer never passes the synchronized write pointer.
    assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!mrs_n)
        (g2b(wq2) - rbin) <= DEPTH_P);

    // R3: a shown word and its flag hold until a read is requested.
    assert_hold_R3: assert property (@(posedge rclk) disable iff (!mrs_n)
        (!or_n && ren_n) |=> (!or_n && $stable(dout)));

    // R11: crossing pointers move by at most one gray bit per edge.
    assert_wgray_step_R11: assert property (@(posedge wclk) disable iff (!mrs_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_step_R11: assert property (@(posedge rclk) disable iff (!mrs_n)
        $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind cff_fifo cff_fifo_chk #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
) chk_i (
    .wclk (wclk),
    .rclk (rclk),
    .mrs_n(mrs_n),
    .wen_n(wen_n),
    .ren_n(ren_n),
    .ir_n (ir_n),
    .or_n (or_n),
    .dout (dout),
    .wbin (wbin),
    .wgray(wgray),
    .rbin (rbin),
    .rgray(rgray),
    .wq2  (wq2),
    .rq2  (rq2)
);

// File: tb/cff_fifo_tb_top.sv
module cff_fifo_tb_top;

    localparam int DATA_W = 18;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              mrs_n = 1'b0;
    logic              wen0_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic              ren1_n;
    logic              oe1_n = 1'b0;
    logic              ir0_n, or0_n, q_oe0;
    logic              ir1_n, or1_n, q_oe1;
    logic [DATA_W-1:0] q0, q1;

    int                nchk = 0;
    int                nbad = 0;
    int                rd_mode = 0;
    logic [DATA_W-1:0] seq = 18'h100;
    logic [DATA_W-1:0] exp_q [$];

    always #2 clk = ~clk;

    // Head of the chain.
    cff_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .mrs_n(mrs_n), .wclk(clk), .wen_n(wen0_n), .d(din), .ir_n(ir0_n),
        .rclk(clk), .ren_n(ir1_n), .oe_n(1'b0), .or_n(or0_n), .q(q0), .q_oe(q_oe0)
    );

    // Tail of the chain: its flags are the handshake of the head.
    cff_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tail_i (
        .mrs_n(mrs_n), .wclk(clk), .wen_n(or0_n), .d(q0), .ir_n(ir1_n),
        .rclk(clk), .ren_n(ren1_n), .oe_n(oe1_n), .or_n(or1_n), .q(q1), .q_oe(q_oe1)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    task automatic write_one(input logic [DATA_W-1:0] v);
        @(negedge clk);
        wen0_n = 1'b0;
        din    = v;
        exp_q.push_back(v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: chooses the tail read strobe and pops the scoreboard.
    always @(negedge clk) begin
        logic rd;
        logic [DATA_W-1:0] e;
        case (rd_mode)
            1: rd = 1'b1;
            2: rd = ($urandom % 2) == 0;
            3: begin rd = 1'b1; rd_mode = 0; end
            default: rd = 1'b0;
        endcase
        if (!mrs_n) rd = 1'b0;
        ren1_n = !rd;
        if (rd && !or1_n) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 word with empty scoreboard", 32'(q1), 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk(q1 == e, "R11 order", 32'(q1), 32'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog R11 act=0 exp=1");
        finish_run();
    end

    initial begin
        int k0, k1, acc, hi, nw;
        ren1_n = 1'b1;
        idle(3);
        chk(or0_n && or1_n, "R1 or_n in reset", 32'({or0_n, or1_n}), 32'h3);
        chk(!ir0_n && !ir1_n, "R1 ir_n in reset", 32'({ir0_n, ir1_n}), 32'h0);
        mrs_n = 1'b1;
        idle(3);
        chk(or1_n, "R1 empty after reset", 32'(or1_n), 32'h1);

        // First-word ripple through an empty chain.
        write_one(seq);
        @(posedge clk);
        @(negedge clk);
        wen0_n = 1'b1;
        k0 = 0;
        k1 = 0;
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (!or0_n && k0 == 0) k0 = k;
            if (!or1_n && k1 == 0) k1 = k;
        end
        chk(k0 == 3, "R2 head fall-through edges", 32'(k0), 32'd3);
        chk(k1 == 7, "R9 chain first-word edges", 32'(k1), 32'd7);
        chk(q1 == seq, "R2 word shown without read", 32'(q1), 32'(seq));
        seq++;

        // Hold with no read.
        idle(10);
        chk(!or1_n && q1 == exp_q[0], "R3 hold", 32'(q1), 32'(exp_q[0]));

        // Output enable mask.
        oe1_n = 1'b1;
        idle(2);
        chk(q1 == '0 && !q_oe1, "R8 masked q", 32'({q_oe1, q1}), 32'h0);
        chk(!or1_n && !ir1_n, "R8 flags unchanged", 32'({or1_n, ir1_n}), 32'h0);
        oe1_n = 1'b0;
        idle(1);
        chk(q1 == exp_q[0] && q_oe1, "R8 word kept", 32'(q1), 32'(exp_q[0]));

        // Consume the word, then read while empty.
        rd_mode = 1;
        idle(2);
        chk(or1_n, "R4 or_n high after last read", 32'(or1_n), 32'h1);
        idle(10);
        chk(or1_n, "R6 read while empty ignored", 32'(or1_n), 32'h1);
        write_one(seq);
        seq++;
        @(negedge clk);
        wen0_n = 1'b1;
        idle(14);
        chk(exp_q.size() == 0 && or1_n, "R6 later word delivered", 32'(exp_q.size()), 32'h0);

        // Reset discards contents.
        rd_mode = 0;
        for (int i = 0; i < 3; i++) begin
            write_one(seq);
            seq++;
        end
        @(negedge clk);
        wen0_n = 1'b1;
        idle(20);
        mrs_n = 1'b0;
        idle(1);
        chk(or0_n && or1_n && !ir0_n && !ir1_n, "R1 flags after reset",
            32'({or0_n, or1_n, ir0_n, ir1_n}), 32'hC);
        exp_q.delete();
        mrs_n = 1'b1;
        idle(15);
        chk(or1_n, "R1 contents discarded", 32'(or1_n), 32'h1);

        // Fill the chain; writes attempted while full carry a stale value.
        acc = 0;
        hi  = 0;
        for (int i = 0; i < 600 && hi < 20; i++) begin
            @(negedge clk);
            wen0_n = 1'b0;
            din    = seq;
            if (!ir0_n) begin
                exp_q.push_back(seq);
                seq++;
                acc++;
                hi = 0;
            end else begin
                hi++;
            end
        end
        @(negedge clk);
        wen0_n = 1'b1;
        chk(acc == 2 * (DEPTH + 1), "R10 chain capacity", 32'(acc), 32'(2 * (DEPTH + 1)));
        chk(ir0_n && ir1_n, "R5 full flags", 32'({ir0_n, ir1_n}), 32'h3);

        // One read from the full chain; measure the free-slot bubble.
        @(posedge clk);
        #1 rd_mode = 3;
        @(negedge clk);
        @(posedge clk);
        k0 = 0;
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) begin
                chk(!or1_n && q1 == exp_q[0], "R4 next word same edge", 32'(q1), 32'(exp_q[0]));
            end
            if (!ir0_n && k0 == 0) k0 = k;
        end
        chk(k0 == 5, "R7 R9 head ir_n after read", 32'(k0), 32'd5);

        // Drain; every word is compared by the monitor.
        rd_mode = 1;
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        idle(15);
        chk(exp_q.size() == 0 && or1_n, "R5 exactly the accepted words", 32'(exp_q.size()), 32'h0);

        // Random stalls on both ends.
        rd_mode = 2;
        nw = 0;
        for (int i = 0; i < 5000 && nw < 600; i++) begin
            @(negedge clk);
            if (!ir0_n && ($urandom % 10) < 6) begin
                wen0_n = 1'b0;
                din    = seq;
                exp_q.push_back(seq);
                seq++;
                nw++;
            end else begin
                wen0_n = 1'b1;
            end
        end
        @(negedge clk);
        wen0_n = 1'b1;
        rd_mode = 1;
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        idle(15);
        chk(nw == 600, "R11 words written", 32'(nw), 32'd600);
        chk(exp_q.size() == 0 && or1_n, "R11 no loss", 32'(exp_q.size()), 32'h0);

        finish_run();
    end

endmodule